// File: doc/BRIEF.md
# Shared GPIO Port With Host Override

This block is a fifteen-pin general-purpose I/O port whose pins can each be lent to a parallel host-interface function. Software configures it over a small single-cycle register bus. An ownership register marks which pins belong to the host function. A direction register makes each GPIO pin an input or an output. A data register holds the values to drive and reports the levels it sees.

While a pin belongs to the host function, the pad is steered only by the host override inputs (output enable and output value). The GPIO direction and data bits still decide what a read of the data register returns. This lets software watch live host traffic, or use the data register as plain storage.

Each pin's incoming level passes through a two-flop synchronizer before anything reads it. The synchronized level is also handed back to the host logic.

Top module: `gpio_host_port`

## Requirements
- R1: After reset, the ownership, direction and data registers all read as zero, and no pad output enable is asserted.
- R2: A GPIO pin whose direction bit is 0 never has its pad output enable asserted. A data write to that pin is still stored, and it becomes visible by switching the pin's direction to 1.
- R3: For a pin whose direction bit is 0, the data-register read returns the pad level after a two-flop synchronizer. A pin change is read as the old level one clock later and as the new level two clocks later.
- R4: A GPIO pin whose direction bit is 1 has its output enable asserted. A value written to its data bit appears on the pad output right after the clock edge that performs the write.
- R5: For a GPIO pin whose direction bit is 1, the data-register read returns the stored data bit, not the pad level.
- R6: For a host-owned pin (ownership bit 1), the pad output enable and output value equal the host override inputs, whatever the direction and data bits hold.
- R7: For a host-owned pin whose direction bit is 0, the data-register read returns the synchronized pad level, whether the host is driving the pin or receiving on it.
- R8: For a host-owned pin whose direction bit is 1, the data-register read returns the stored data bit.
- R9: The register addresses are: 0 for ownership (bit i = 1 gives pin i to the host), 1 for direction, and 2 for data. Address 3 reads as zero, and writes to it change nothing.
- R10: While the select input is low, writes are ignored and the read data bus is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_sel | input | 1 | Register access select |
| reg_wr | input | 1 | Write strobe (valid with reg_sel) |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 15 | Write data |
| reg_rdata | output | 15 | Read data, combinational from address |
| pad_in | input | 15 | Level seen on each pin |
| pad_oe | output | 15 | Pad output enable per pin |
| pad_out | output | 15 | Pad output value per pin |
| host_oe | input | 15 | Host-function output enable override |
| host_out | input | 15 | Host-function output value override |
| host_own | output | 15 | Pins currently owned by the host function |
| host_in | output | 15 | Synchronized pin levels for the host logic |

## Verification
The bench sweeps many combinations of ownership, direction, data, external level and host override values. For each one it computes the resolved pin level and the expected read value arithmetically.

- A design that let GPIO bits leak onto host-owned pads would show a wrong pad enable or value.
- A design that chose the read source by ownership rather than by direction would return pin levels where stored bits are expected.
- A design with one synchronizer stage too few or too many would fail the one-clock and two-clock timing probes.

The bench also checks that a write to an input pin is kept but never driven, that a write appears on the pad exactly one edge later, and that the unused address and a deselected bus change nothing.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
    localparam int PORT_W = 15;
    localparam int ADDR_W = 2;
    localparam int SYNC_STAGES = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_OWNER = 2'd0,
        REG_DIR   = 2'd1,
        REG_DATA  = 2'd2,
        REG_SPARE = 2'd3
    } reg_addr_e;

    // One pad's drive request.
    typedef struct packed {
        logic oe;
        logic val;
    } pad_drv_t;

    // Data-register read view: stored bit when direction is 1, synchronized pin otherwise.
    function automatic logic view_bit(input logic dir, input logic stored, input logic pin);
        return dir ? stored : pin;
    endfunction

    function automatic pad_drv_t pick_drv(input logic host, input pad_drv_t h, input pad_drv_t g);
        return host ? h : g;
    endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W      = 15,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < STAGES; k++) chain[k] <= '0;
        end else begin
            chain[0] <= d;
            for (int k = 1; k < STAGES; k++) chain[k] <= chain[k-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_port_pkg::*;
#(
    parameter int W  = PORT_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sel,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wdata,
    input  logic [W-1:0]  pin_sync,
    output logic [W-1:0]  owner_q,
    output logic [W-1:0]  dir_q,
    output logic [W-1:0]  data_q,
    output logic [W-1:0]  rdata
);
    logic wen;
    assign wen = sel && wr;

    always_ff @(posedge clk) begin
        if (rst) begin
            owner_q <= '0;
            dir_q   <= '0;
            data_q  <= '0;
        end else if (wen) begin
            case (addr)
                REG_OWNER: owner_q <= wdata;
                REG_DIR:   dir_q   <= wdata;
                REG_DATA:  data_q  <= wdata;
                default:   ;
            endcase
        end
    end

    logic [W-1:0] data_view;
    for (genvar i = 0; i < W; i++) begin : g_view
        assign data_view[i] = view_bit(dir_q[i], data_q[i], pin_sync[i]);
    end

    always_comb begin
        rdata = '0;
        if (sel) begin
            case (addr)
                REG_OWNER: rdata = owner_q;
                REG_DIR:   rdata = dir_q;
                REG_DATA:  rdata = data_view;
                default:   rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux
    import gpio_port_pkg::*;
#(
    parameter int W = PORT_W
) (
    input  logic [W-1:0] owner,
    input  logic [W-1:0] dir,
    input  logic [W-1:0] data,
    input  logic [W-1:0] h_oe,
    input  logic [W-1:0] h_out,
    output logic [W-1:0] oe,
    output logic [W-1:0] out
);
    for (genvar i = 0; i < W; i++) begin : g_pin
        pad_drv_t gpio_d, host_d, sel_d;
        assign gpio_d = '{oe: dir[i],  val: data[i]};
        assign host_d = '{oe: h_oe[i], val: h_out[i]};
        assign sel_d  = pick_drv(owner[i], host_d, gpio_d);
        assign oe[i]  = sel_d.oe;
        assign out[i] = sel_d.val;
    end
endmodule

// File: rtl/gpio_host_port.sv
module gpio_host_port
    import gpio_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_sel,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [PORT_W-1:0] reg_wdata,
    output logic [PORT_W-1:0] reg_rdata,
    input  logic [PORT_W-1:0] pad_in,
    output logic [PORT_W-1:0] pad_oe,
    output logic [PORT_W-1:0] pad_out,
    input  logic [PORT_W-1:0] host_oe,
    input  logic [PORT_W-1:0] host_out,
    output logic [PORT_W-1:0] host_own,
    output logic [PORT_W-1:0] host_in
);
    logic [PORT_W-1:0] pin_sync;
    logic [PORT_W-1:0] owner_q;
    logic [PORT_W-1:0] dir_q;
    logic [PORT_W-1:0] data_q;

    gpio_sync #(.W(PORT_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pad_in),
        .q   (pin_sync)
    );

    gpio_regs #(.W(PORT_W), .AW(ADDR_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .sel      (reg_sel),
        .wr       (reg_wr),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .pin_sync (pin_sync),
        .owner_q  (owner_q),
        .dir_q    (dir_q),
        .data_q   (data_q),
        .rdata    (reg_rdata)
    );

    gpio_pad_mux #(.W(PORT_W)) u_mux (
        .owner (owner_q),
        .dir   (dir_q),
        .data  (data_q),
        .h_oe  (host_oe),
        .h_out (host_out),
        .oe    (pad_oe),
        .out   (pad_out)
    );

    assign host_own = owner_q;
    assign host_in  = pin_sync;
endmodule

// File: rtl/gpio_host_port_chk.sv
module gpio_host_port_chk
    import gpio_port_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              reg_sel,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [PORT_W-1:0] reg_wdata,
    input logic [PORT_W-1:0] reg_rdata,
    input logic [PORT_W-1:0] pad_in,
    input logic [PORT_W-1:0] pad_oe,
    input logic [PORT_W-1:0] pad_out,
    input logic [PORT_W-1:0] host_oe,
    input logic [PORT_W-1:0] host_out,
    input logic [PORT_W-1:0] host_own,
    input logic [PORT_W-1:0] dir_q
);
    logic [1:0] seen;
    always_ff @(posedge clk) begin
        if (rst) seen <= '0;
        else if (seen != 2'd3) seen <= seen + 2'd1;
    end

    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (pad_oe == '0 && dir_q == '0));

    assert_input_no_drive_R2: assert property (@(posedge clk) disable iff (rst)
        ((pad_oe ^ dir_q) & ~host_own) == '0);

    assert_input_sync_R3: assert property (@(posedge clk) disable iff (rst)
        (seen >= 2'd2 && reg_sel && !reg_wr && reg_addr == REG_DATA)
        |-> (((reg_rdata ^ $past(pad_in, 2)) & ~dir_q) == '0));

    assert_write_visible_R4: assert property (@(posedge clk) disable iff (rst)
        (reg_sel && reg_wr && reg_addr == REG_DATA)
        |=> (((pad_out ^ $past(reg_wdata)) & pad_oe & ~host_own) == '0));

    assert_host_override_R6: assert property (@(posedge clk) disable iff (rst)
        (((pad_oe ^ host_oe) & host_own) == '0) &&
        (((pad_out ^ host_out) & host_own & host_oe) == '0));

    assert_idle_bus_R10: assert property (@(posedge clk) disable iff (rst)
        !reg_sel |-> (reg_rdata == '0));
endmodule

bind gpio_host_port gpio_host_port_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_sel   (reg_sel),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .pad_in    (pad_in),
    .pad_oe    (pad_oe),
    .pad_out   (pad_out),
    .host_oe   (host_oe),
    .host_out  (host_out),
    .host_own  (host_own),
    .dir_q     (dir_q)
);

// File: tb/tb_gpio_host_port.sv
module tb_gpio_host_port;
    localparam int W = 15;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         reg_sel = 1'b0;
    logic         reg_wr = 1'b0;
    logic [1:0]   reg_addr = '0;
    logic [W-1:0] reg_wdata = '0;
    logic [W-1:0] reg_rdata;
    logic [W-1:0] pad_in;
    logic [W-1:0] pad_oe;
    logic [W-1:0] pad_out;
    logic [W-1:0] host_oe = '0;
    logic [W-1:0] host_out = '0;
    logic [W-1:0] host_own;
    logic [W-1:0] host_in;
    logic [W-1:0] ext = '0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    // Resolved pin: the pad drives when enabled, otherwise the outside world sets the level.
    assign pad_in = (pad_oe & pad_out) | (~pad_oe & ext);

    gpio_host_port dut (
        .clk       (clk),
        .rst       (rst),
        .reg_sel   (reg_sel),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .pad_in    (pad_in),
        .pad_oe    (pad_oe),
        .pad_out   (pad_out),
        .host_oe   (host_oe),
        .host_out  (host_out),
        .host_own  (host_own),
        .host_in   (host_in)
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [W-1:0] v);
        @(negedge clk);
        reg_sel = 1'b1; reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_sel = 1'b0; reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [W-1:0] v);
        @(negedge clk);
        reg_sel = 1'b1; reg_wr = 1'b0; reg_addr = a;
        #2 v = reg_rdata;
        reg_sel = 1'b0;
    endtask

    initial begin
        #4000000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] v;
        logic [W-1:0] m, d, w, e, hoe, hout, exp_oe, exp_out, pin;
        ext = 15'h2AD3;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #2;
        check("R1 oe", pad_oe, '0);
        rd_reg(2'd0, v); check("R1 owner", v, '0);
        rd_reg(2'd1, v); check("R1 dir", v, '0);

        // R2: writes to input pins are stored but not driven
        wr_reg(2'd2, 15'h1234);
        #2 check("R2 no drive", pad_oe, '0);
        wr_reg(2'd1, '1);
        rd_reg(2'd2, v); check("R2 stored", v, 15'h1234);
        check("R4 out after dir", pad_out, 15'h1234);

        // R4: write visible right after the writing edge
        @(negedge clk);
        reg_sel = 1'b1; reg_wr = 1'b1; reg_addr = 2'd2; reg_wdata = 15'h6B1E;
        #2 check("R4 before edge", pad_out, 15'h1234);
        @(negedge clk);
        reg_sel = 1'b0; reg_wr = 1'b0;
        #2 check("R4 after edge", pad_out, 15'h6B1E);

        // R3: synchronizer latency
        wr_reg(2'd1, '0);
        ext = 15'h0F0F;
        repeat (3) @(negedge clk);
        ext = 15'h70F0;
        rd_reg(2'd2, v); check("R3 one clock old", v, 15'h0F0F);
        rd_reg(2'd2, v); check("R3 two clocks new", v, 15'h70F0);

        // Sweep of ownership/direction/data/pin/host patterns
        for (int i = 0; i < 20; i++) begin
            case (i)
                0: begin m = '0; d = '0; end
                1: begin m = '0; d = '1; end
                2: begin m = '1; d = '0; end
                3: begin m = '1; d = '1; end
                default: begin
                    m = W'((i * 9973) ^ 16'h5A5A);
                    d = W'((i * 4661) ^ 16'h3C96);
                end
            endcase
            w    = W'((i * 7919) ^ 16'h1F2E);
            e    = W'((i * 3331) ^ 16'h6D4B);
            hoe  = W'((i * 2203) ^ 16'h0E71);
            hout = W'((i * 5557) ^ 16'h4B2D);
            wr_reg(2'd0, m);
            wr_reg(2'd1, d);
            wr_reg(2'd2, w);
            ext = e; host_oe = hoe; host_out = hout;
            repeat (3) @(negedge clk);
            exp_oe  = (m & hoe) | (~m & d);
            exp_out = (m & hout) | (~m & w);
            pin     = (exp_oe & exp_out) | (~exp_oe & e);
            #2;
            check("R2 R4 R6 pad_oe", pad_oe, exp_oe);
            check("R4 R6 pad_out", pad_out & exp_oe, exp_out & exp_oe);
            check("R6 host_own", host_own, m);
            rd_reg(2'd0, v); check("R9 owner readback", v, m);
            rd_reg(2'd1, v); check("R9 dir readback", v, d);
            rd_reg(2'd2, v); check("R3 R5 R7 R8 data view", v, (d & w) | (~d & pin));
        end

        // R9: spare address
        wr_reg(2'd0, 15'h0101);
        wr_reg(2'd1, '1);
        wr_reg(2'd2, 15'h2222);
        wr_reg(2'd3, '1);
        rd_reg(2'd3, v); check("R9 spare reads zero", v, '0);
        rd_reg(2'd0, v); check("R9 owner kept", v, 15'h0101);
        rd_reg(2'd1, v); check("R9 dir kept", v, '1);
        rd_reg(2'd2, v); check("R9 data kept", v, 15'h2222);

        // R10: deselected bus
        @(negedge clk);
        reg_sel = 1'b0; reg_wr = 1'b1; reg_addr = 2'd2; reg_wdata = 15'h5555;
        #2 check("R10 rdata zero", reg_rdata, '0);
        @(negedge clk);
        reg_wr = 1'b0;
        rd_reg(2'd2, v); check("R10 write ignored", v, 15'h2222);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule